// File: doc/BRIEF.md
# Bus Cycle Timeout Watchdog

This block watches the shared address strobe and catches bus cycles that nobody acknowledges. Any master can own the bus, on-chip or off-chip. When a new strobe assertion arrives while the watchdog is enabled, the block loads a timeout value into a down counter and clears a prescaler. The counter then steps down once per full prescaler wrap. If the counter has run down to zero and the strobe is still asserted, the block pulls its active-low bus error output low. It keeps bus error asserted until the strobe is released. It also sets a sticky status flag that records the event.

The enable bit is held in a small register that powers up set, so the watchdog runs from reset. A write with the enable value low turns the watchdog off. It drops any bus error in progress at once, and no later cycle is armed until the watchdog is enabled again. The status flag stays set until a clear pulse or reset. When a timeout and a clear pulse arrive in the same cycle, the timeout wins.

Top module: `bus_wdog`

## Requirements
- R1: After reset, busErrN is 1, timeoutFlag is 0, and the watchdog is enabled.
- R2: Let D = 2**PRE_W and let T be the value on timeoutVal at arming. Call the first rising edge that samples addrStrobeN low (with the previous sample high) edge 1. With the watchdog enabled, busErrN goes low right after edge number D*T+2, counting only edges at which addrStrobeN stays low.
- R3: If addrStrobeN is sampled high before edge D*T+2, busErrN stays 1 for the whole cycle and timeoutFlag is not set.
- R4: Once busErrN is low, it stays low while addrStrobeN is low. It returns to 1 right after the first edge that samples addrStrobeN high.
- R5: timeoutFlag is set by the same edge that asserts bus error and stays set until an edge samples flagClr high. A timeout in that same cycle keeps it set.
- R6: An edge sampling cfgWr=1 with cfgEn=0 disables the watchdog and returns busErrN to 1 after that edge. While disabled, busErrN stays 1 and timeoutFlag is not set, however long the strobe is held. An edge sampling cfgWr=1 with cfgEn=1 enables it again.
- R7: Every new strobe assertion reloads the counter from timeoutVal and clears the prescaler. Time spent in earlier cycles is never carried over.
- R8: A cycle is armed only by a high-to-low strobe transition seen while enabled. Enabling the watchdog in the middle of an asserted strobe does not time that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrStrobeN | input | 1 | Bus address strobe, active low |
| timeoutVal | input | CNT_W | Timeout count, loaded on arming |
| cfgWr | input | 1 | Write strobe for the enable bit |
| cfgEn | input | 1 | Enable value written by cfgWr |
| flagClr | input | 1 | Clears the timeout flag when high |
| busErrN | output | 1 | Bus error, active low |
| timeoutFlag | output | 1 | Sticky timeout status |

## Verification
The bench builds the block with PRE_W=2 and CNT_W=6, so one counter step takes only four clocks. At that size the exact bus-error edge for timeouts of 0 to 5 falls within a few dozen clocks, and random strobe lengths land on both sides of the threshold often. The zero-timeout case and the one-edge-early case are reached directly. A second build with PRE_W=0 is not used, but the generate branch for it leaves the counter stepping on every clock.

// File: rtl/bus_wdog_pkg.sv
package bus_wdog_pkg;
  typedef struct packed {
    logic load;  // arm: reload counter, clear prescaler
    logic run;   // advance prescaler / counter this cycle
  } wdog_strobe_t;
endpackage

// File: rtl/bus_wdog_datapath.sv
module bus_wdog_datapath
  import bus_wdog_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdog_strobe_t     strb,
  input  logic [CNT_W-1:0] timeoutVal,
  output logic             cntZero
);
  logic [CNT_W-1:0] cnt;
  logic             stepTick;

  generate
    if (PRE_W > 0) begin : g_pre
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          pre <= '0;
        else if (strb.load) pre <= '0;
        else if (strb.run)  pre <= pre + 1'b1;
      end
      assign stepTick = strb.run && (&pre);
    end else begin : g_nopre
      assign stepTick = strb.run;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        cnt <= '0;
    else if (strb.load)               cnt <= timeoutVal;
    else if (stepTick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);
endmodule

// File: rtl/bus_wdog_ctrl.sv
module bus_wdog_ctrl
  import bus_wdog_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrStrobeN,
  input  logic         cfgWr,
  input  logic         cfgEn,
  input  logic         flagClr,
  input  logic         cntZero,
  output wdog_strobe_t strb,
  output logic         busErrN,
  output logic         timeoutFlag
);
  logic enReg, prevStrobeN, active, errReg;
  logic strobeOn, killNow, expire;

  assign strobeOn  = !addrStrobeN;
  assign killNow   = !enReg || (cfgWr && !cfgEn) || addrStrobeN;
  assign strb.load = enReg && strobeOn && prevStrobeN;
  assign strb.run  = active && strobeOn && !errReg;
  assign expire    = active && !killNow && cntZero && !errReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg       <= 1'b1;
      prevStrobeN <= 1'b1;
      active      <= 1'b0;
      errReg      <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      prevStrobeN <= addrStrobeN;
      if (cfgWr) enReg <= cfgEn;
      if (killNow) begin
        active <= 1'b0;
        errReg <= 1'b0;
      end else if (strb.load) begin
        active <= 1'b1;
      end else if (expire) begin
        errReg <= 1'b1;
      end
      if (expire)       timeoutFlag <= 1'b1;
      else if (flagClr) timeoutFlag <= 1'b0;
    end
  end

  assign busErrN = !errReg;
endmodule

// File: rtl/bus_wdog.sv
module bus_wdog
  import bus_wdog_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrStrobeN,
  input  logic [CNT_W-1:0] timeoutVal,
  input  logic             cfgWr,
  input  logic             cfgEn,
  input  logic             flagClr,
  output logic             busErrN,
  output logic             timeoutFlag
);
  wdog_strobe_t strb;
  logic         cntZero;

  bus_wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addrStrobeN(addrStrobeN), .cfgWr(cfgWr),
    .cfgEn(cfgEn), .flagClr(flagClr), .cntZero(cntZero), .strb(strb),
    .busErrN(busErrN), .timeoutFlag(timeoutFlag)
  );

  bus_wdog_datapath #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .timeoutVal(timeoutVal),
    .cntZero(cntZero)
  );
endmodule

// File: rtl/bus_wdog_chk.sv
module bus_wdog_chk (
  input logic clk,
  input logic rstN,
  input logic addrStrobeN,
  input logic cfgWr,
  input logic cfgEn,
  input logic flagClr,
  input logic busErrN,
  input logic timeoutFlag
);
  // R4
  err_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busErrN && addrStrobeN) |=> busErrN);

  // R4
  err_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busErrN) |-> $past(!addrStrobeN));

  // R5
  flag_with_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busErrN) |-> timeoutFlag);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !flagClr) |=> timeoutFlag);

  // R6
  disable_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !cfgEn) |=> busErrN);
endmodule

bind bus_wdog bus_wdog_chk u_chk (
  .clk(clk), .rstN(rstN), .addrStrobeN(addrStrobeN), .cfgWr(cfgWr),
  .cfgEn(cfgEn), .flagClr(flagClr), .busErrN(busErrN),
  .timeoutFlag(timeoutFlag)
);

// File: tb/bus_wdog_tb.sv
module bus_wdog_tb;
  localparam int PRE_W = 2;
  localparam int CNT_W = 6;
  localparam int D = 1 << PRE_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrStrobeN = 1'b1;
  logic [CNT_W-1:0] timeoutVal = '0;
  logic cfgWr = 1'b0, cfgEn = 1'b0, flagClr = 1'b0;
  logic busErrN, timeoutFlag;

  int nChecks = 0, nFails = 0;
  bit modelEn = 1'b1;
  bit modelFlag = 1'b0;

  always #5 clk = ~clk;

  bus_wdog #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .addrStrobeN(addrStrobeN), .timeoutVal(timeoutVal),
    .cfgWr(cfgWr), .cfgEn(cfgEn), .flagClr(flagClr),
    .busErrN(busErrN), .timeoutFlag(timeoutFlag)
  );

  function automatic bit expErr(int t, int k, bit en);
    return en && (k >= D * t + 2);
  endfunction

  task automatic check(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeEn(bit v);
    @(negedge clk); cfgWr = 1'b1; cfgEn = v;
    @(negedge clk); cfgWr = 1'b0;
    modelEn = v;
  endtask

  task automatic clearFlag();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    modelFlag = 1'b0;
    #1 check("R5 clear", timeoutFlag, 1'b0);
  endtask

  // one bus cycle: strobe held low for 'hold' edges, then released
  task automatic busCycle(int t, int hold, string req);
    bit hit = 1'b0;
    @(negedge clk); timeoutVal = CNT_W'(t); addrStrobeN = 1'b0;
    for (int k = 1; k <= hold; k++) begin
      @(posedge clk); #1;
      hit = expErr(t, k, modelEn);
      check(req, busErrN, !hit);
    end
    if (hit) modelFlag = 1'b1;
    @(negedge clk); addrStrobeN = 1'b1;
    @(posedge clk); #1;
    check("R4 release", busErrN, 1'b1);
    check("R5 flag", timeoutFlag, modelFlag);
  endtask

  initial begin
    #2_000_000;
    nFails++; nChecks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 berr", busErrN, 1'b1);
    check("R1 flag", timeoutFlag, 1'b0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);

    // R1 enabled from reset, R2 zero timeout and exact threshold
    busCycle(0, 4, "R1 R2 t0");
    clearFlag();
    busCycle(3, D*3+3, "R2 t3");
    clearFlag();
    // R3 one edge early
    busCycle(3, D*3+1, "R3 early");
    // R7 short cycles then threshold cycle
    busCycle(2, D*2, "R7 a");
    busCycle(2, D*2, "R7 b");
    busCycle(2, D*2+2, "R7 c");
    // R5 set wins over clear in the same cycle
    clearFlag();
    @(negedge clk); timeoutVal = '0; addrStrobeN = 1'b0; // edge1 arm
    @(negedge clk); flagClr = 1'b1;                     // edge2 expire
    @(negedge clk); flagClr = 1'b0; #1;
    check("R5 set wins", timeoutFlag, 1'b1);
    check("R4 held", busErrN, 1'b0);
    // R6 disable while error held
    @(negedge clk); cfgWr = 1'b1; cfgEn = 1'b0;
    @(negedge clk); cfgWr = 1'b0; modelEn = 1'b0; #1;
    check("R6 drop", busErrN, 1'b1);
    @(negedge clk); addrStrobeN = 1'b1;
    @(negedge clk);
    modelFlag = 1'b1;
    clearFlag();
    busCycle(0, 20, "R6 disabled");
    // R8 enable mid-strobe does not arm
    @(negedge clk); timeoutVal = '0; addrStrobeN = 1'b0;
    @(negedge clk); cfgWr = 1'b1; cfgEn = 1'b1;
    @(negedge clk); cfgWr = 1'b0; modelEn = 1'b1;
    repeat (10) begin
      @(posedge clk); #1;
      check("R8 mid", busErrN, 1'b1);
    end
    check("R8 flag", timeoutFlag, 1'b0);
    @(negedge clk); addrStrobeN = 1'b1;
    @(negedge clk);
    busCycle(1, D+3, "R8 rearm R2");
    clearFlag();

    // random mix
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 60; i++) begin
      int t = $urandom_range(0, 5);
      int h = $urandom_range(1, D*t + 6);
      if ($urandom_range(0, 5) == 0) writeEn(!modelEn);
      busCycle(t, h, "R2 R3 rand");
      if ($urandom_range(0, 3) == 0) clearFlag();
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule